// File: doc/BRIEF.md
# Cascadable Up/Down Counter Stage

This block is a small synchronous binary counter that can run in either direction. While the active-low enable is held low, every rising clock edge moves the whole count by one step together. The direction input picks whether that step goes up or down. A preset value can be forced into the counter at any moment through an active-low load input, without waiting for a clock edge. This lets the stage act as a modulo-N divider when the preset value is chosen to match.

Two outputs support chaining. The first is a terminal flag that goes high when the count sits at the end of its range for the current direction. The second is an active-low carry clock, which pulses low during the low half of the clock while the stage is enabled and at that end. Stages can be chained in two ways. With a shared clock, each stage's carry clock feeds the next stage's enable. With a shared enable, each stage's carry clock feeds the next stage's clock. The rising edge of the carry clock falls on the same clock edge at which the lower stage wraps.

Top module: `updown_stage`

## Requirements
- R1: On a rising `clk` edge with `cntEnN` low and `loadN` high, `count` changes by exactly one, all bits in the same edge.
- R2: On a rising `clk` edge with `cntEnN` high and `loadN` high, `count` keeps its value.
- R3: With `dirDown` = 0 the step is +1; with `dirDown` = 1 the step is -1.
- R4: Counting wraps. Going up, all-ones (15 at WIDTH = 4) is followed by 0. Going down, 0 is followed by all-ones.
- R5: A falling edge on `loadN` copies `presetVal` into `count` at once, with no clock edge needed.
- R6: While `loadN` is low, each rising `clk` edge reloads `presetVal` and does not count, even with `cntEnN` low.
- R7: `termCount` is 1 exactly when `count` is all-ones with `dirDown` = 0, or zero with `dirDown` = 1. The level of `cntEnN` has no effect on it.
- R8: `carryClkN` is 0 only while `termCount` = 1, `cntEnN` = 0 and `clk` = 0. Otherwise it is 1.
- R9: Two stages with a shared enable and direction form one 2×WIDTH-bit counter in both directions. The lower stage runs on `clk` and the upper stage is clocked by the lower stage's `carryClkN`.
- R10: While `rstN` is low, `count` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; rising edge active |
| rstN | input | 1 | Asynchronous reset to zero, active low |
| loadN | input | 1 | Asynchronous preset strobe, active low |
| cntEnN | input | 1 | Count enable, active low |
| dirDown | input | 1 | Direction: 0 up, 1 down |
| presetVal | input | WIDTH | Value taken on load |
| count | output | WIDTH | Current count |
| termCount | output | 1 | End-of-range flag for the current direction |
| carryClkN | output | 1 | Active-low carry pulse in the clock low phase |

## Verification
The bench builds every instance with the default WIDTH of 4. At that width all sixteen count values can be visited in both directions in a few dozen cycles, so each wrap point and each terminal-flag case is reached directly. The two-stage chain, also at WIDTH = 4, gives an 8-bit count. A run of forty steps up, and then twenty back down, crosses the upper stage's carry in both directions.

// File: rtl/updown_pkg.sv
package updown_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic advance;  // take one step this edge
    logic goDown;   // step direction: 1 = decrement
  } stepCtl_t;
endpackage

// File: rtl/updown_control.sv
module updown_control
  import updown_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEnN,
  input  logic             dirDown,
  input  logic [WIDTH-1:0] count,
  output stepCtl_t         stepCtl,
  output logic             termCount,
  output logic             carryClkN
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  logic atTop;
  logic atBottom;
  logic atEnd;

  always_comb begin
    stepCtl.advance = !cntEnN;
    stepCtl.goDown  = dirDown;
  end

  assign atTop     = (count == ALL_ONES);
  assign atBottom  = (count == ALL_ZERO);
  assign atEnd     = dirDown ? atBottom : atTop;
  assign termCount = atEnd;
  // Low only in the low clock phase of an enabled terminal state
  assign carryClkN = !(atEnd && !cntEnN && !clk);

  AST_TERM_UP_END: assert property (@(posedge clk) disable iff (!rstN)
    (termCount && !dirDown) |-> (count == ALL_ONES)); // R7
  AST_TERM_DOWN_END: assert property (@(posedge clk) disable iff (!rstN)
    (termCount && dirDown) |-> (count == ALL_ZERO)); // R7
endmodule

// File: rtl/updown_datapath.sv
module updown_datapath
  import updown_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] presetVal,
  input  stepCtl_t         stepCtl,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] countNext;

  always_comb begin
    countNext = countQ;
    if (stepCtl.advance) begin
      countNext = stepCtl.goDown ? (countQ - ONE) : (countQ + ONE);
    end
  end

  always_ff @(posedge clk or negedge rstN or negedge loadN) begin
    if (!rstN)      countQ <= '0;
    else if (!loadN) countQ <= presetVal;
    else            countQ <= countNext;
  end

  assign count = countQ;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!stepCtl.advance && loadN) |=> (!loadN || $stable(count))); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (stepCtl.advance && !stepCtl.goDown && loadN)
      |=> (!loadN || count == WIDTH'($past(count) + ONE))); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (stepCtl.advance && stepCtl.goDown && loadN)
      |=> (!loadN || count == WIDTH'($past(count) - ONE))); // R4
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |=> (count == $past(presetVal))); // R6
endmodule

// File: rtl/updown_stage.sv
module updown_stage
  import updown_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadN,
  input  logic             cntEnN,
  input  logic             dirDown,
  input  logic [WIDTH-1:0] presetVal,
  output logic [WIDTH-1:0] count,
  output logic             termCount,
  output logic             carryClkN
);
  stepCtl_t stepCtl;

  updown_control #(.WIDTH(WIDTH)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .cntEnN    (cntEnN),
    .dirDown   (dirDown),
    .count     (count),
    .stepCtl   (stepCtl),
    .termCount (termCount),
    .carryClkN (carryClkN)
  );

  updown_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .loadN     (loadN),
    .presetVal (presetVal),
    .stepCtl   (stepCtl),
    .count     (count)
  );
endmodule

// File: tb/updown_stage_bench.sv
module updown_stage_bench;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rstN, loadN, cntEnN, dirDown;
  logic [W-1:0] presetVal;
  logic [W-1:0] count;
  logic termCount, carryClkN;

  // cascade pair
  logic casRstN, casEnN, casDn;
  logic [W-1:0] loCount, hiCount;
  logic loTerm, hiTerm, loCarryN, hiCarryN;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  updown_stage #(.WIDTH(W)) u_updown_stage (
    .clk(clk), .rstN(rstN), .loadN(loadN), .cntEnN(cntEnN), .dirDown(dirDown),
    .presetVal(presetVal), .count(count), .termCount(termCount), .carryClkN(carryClkN));

  updown_stage #(.WIDTH(W)) u_casLo (
    .clk(clk), .rstN(casRstN), .loadN(1'b1), .cntEnN(casEnN), .dirDown(casDn),
    .presetVal('0), .count(loCount), .termCount(loTerm), .carryClkN(loCarryN));

  updown_stage #(.WIDTH(W)) u_casHi (
    .clk(loCarryN), .rstN(casRstN), .loadN(1'b1), .cntEnN(casEnN), .dirDown(casDn),
    .presetVal('0), .count(hiCount), .termCount(hiTerm), .carryClkN(hiCarryN));

  // {enN, down, expCount[3:0], expTerm, expCarryLow}
  localparam logic [7:0] VEC [0:9] = '{
    8'b0_0_0001_0_0,  // up 0->1
    8'b1_0_0001_0_0,  // hold
    8'b0_1_0000_1_1,  // down to 0, terminal, carry pulses
    8'b1_1_0000_1_0,  // hold at 0, terminal, carry held high
    8'b0_1_1111_0_0,  // wrap down 0->15
    8'b1_0_1111_1_0,  // hold at 15 going up, terminal
    8'b0_0_0000_0_0,  // wrap up 15->0
    8'b0_1_1111_0_0,  // wrap down again
    8'b0_0_0000_0_0,  // wrap up again
    8'b0_0_0001_0_0   // up 0->1
  };

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts in clock low phase, ends in the next low phase
  task automatic stepChk(logic enN, logic dn, int expCnt, int expTerm, int expLow, string req);
    cntEnN = enN;
    dirDown = dn;
    @(posedge clk);
    #5;
    chk(req, int'(count), expCnt);
    chk("R7 term", int'(termCount), expTerm);
    chk("R8 carry high phase", int'(carryClkN), 1);
    #10;
    chk("R8 carry low phase", int'(carryClkN), expLow ? 0 : 1);
  endtask

  task automatic loadChk(int val);
    presetVal = W'(val);
    cntEnN = 1'b0;
    loadN = 1'b0;
    #1;
    chk("R5 async load", int'(count), val);
    @(posedge clk);
    #5;
    chk("R6 load beats count", int'(count), val);
    loadN = 1'b1;
    #10;
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; loadN = 1'b1; cntEnN = 1'b1; dirDown = 1'b0; presetVal = '0;
    casRstN = 1'b0; casEnN = 1'b1; casDn = 1'b0;
    #15;
    chk("R10 reset count", int'(count), 0);
    dirDown = 1'b1;
    #1;
    chk("R7 term at 0 down while held", int'(termCount), 1);
    #10;  // t=26, clk low
    chk("R8 carry stays high when disabled", int'(carryClkN), 1);
    dirDown = 1'b0;
    rstN = 1'b1;

    for (int i = 0; i < 10; i++) begin
      stepChk(VEC[i][7], VEC[i][6], int'(VEC[i][5:2]), int'(VEC[i][1]),
              int'(VEC[i][0]), "R1 R2 R3 R4 vector");
    end

    // full sweep up from 0
    loadChk(0);
    for (int i = 1; i <= 17; i++) begin
      stepChk(1'b0, 1'b0, i % 16, (i % 16) == 15, (i % 16) == 15, "R3 sweep up");
    end
    // full sweep down from 5
    loadChk(5);
    for (int i = 1; i <= 17; i++) begin
      stepChk(1'b0, 1'b1, (5 - i + 32) % 16, ((5 - i + 32) % 16) == 0,
              ((5 - i + 32) % 16) == 0, "R4 sweep down");
    end

    // modulo-style preset then count on
    loadChk(13);
    stepChk(1'b0, 1'b0, 14, 0, 0, "R1 after preset");
    stepChk(1'b1, 1'b0, 14, 0, 0, "R2 hold after preset");

    // cascade: shared enable, lower carry clocks upper stage
    casRstN = 1'b1;
    casEnN = 1'b0;
    casDn = 1'b0;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk);
      #5;
      chk("R9 cascade up", int'({hiCount, loCount}), i);
    end
    casDn = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      @(posedge clk);
      #5;
      chk("R9 cascade down", int'({hiCount, loCount}), 40 - i);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule